// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command front end of a byte-wide NOR flash model. The host presents write cycles as an address, a data byte and a one-cycle strobe. The block matches the two-write unlock prefix and the command byte that follows it. It then decides which operation the flash core should run: byte program, whole-chip erase, erase of one or more 64 KB sectors, identification (autoselect) mode, or suspend and resume of a running sector erase. Reads of the array, pulse timing and the high-voltage identification path sit outside the block.

The block reports its state on a 3-bit mode code. It issues one-cycle start pulses to the embedded algorithm, together with the latched program address and data. It also drives an eight-bit mask of the sectors chosen for erasure. After a sector erase command, a retriggerable window counted in clock cycles collects further sectors before the erase starts. A flag reports when that window has closed, for use as the erase-timer status bit. An external busy input tells the block when a started program or erase has finished.

Top module: `nor_cmd_decoder`

## Requirements
- R1: After synchronous reset, mode_o is 0 (read array), sector_mask_o is 0, win_done_o and erase_chip_o are 0, and no start pulse is high.
- R2: A command begins with the unlock pair: data AAh at command address 555h, then 55h at 2AAh. Only wr_addr[10:0] is compared. Any mismatching write throws the partial sequence away without action, and the block stays in its base mode (read array, or suspended when suspended).
- R3: Unlock followed by A0h at 555h makes the next write the program cycle. Its address and data are latched as-is, even if the data is F0h. prog_start_o is high for one cycle, and mode_o becomes 2 (or 7 when suspended).
- R4: Unlock followed by 90h at 555h enters autoselect, mode_o 1. Only a write of F0h (any address) leaves it, back to mode 0. Every other write is ignored.
- R5: Unlock, 80h at 555h, unlock, then 30h at any address opens the collection window, mode_o 3. That write sets bit wr_addr[18:16] of sector_mask_o. Each further 30h write during the window sets its sector's bit and restarts the window.
- R6: The window ends WIN_CYCLES clock edges after the edge that accepted the last 30h write. At that point erase_start_o pulses for one cycle, mode_o becomes 4 and win_done_o goes to 1. Any write other than 30h or B0h during the window returns to mode 0 and clears the mask.
- R7: Unlock, 80h at 555h, unlock, then 10h at 555h starts a chip erase at once: erase_start_o pulses, mode_o becomes 4, erase_chip_o is 1 and sector_mask_o is all ones.
- R8: In modes 2 and 4, the only write that has any effect is B0h during a sector erase. A high-to-low transition of busy_i ends the operation: mode_o returns to 0, and the mask, erase_chip_o and win_done_o are cleared.
- R9: B0h suspends a sector erase (mode_o 5). Sent during the window, it closes the window, sets win_done_o and gives no erase_start_o. B0h is ignored during a chip erase and during a program.
- R10: In mode 5 with no partial sequence, 30h resumes the erase (mode_o 4). erase_start_o pulses on resume only if the erase had been suspended before it ever started. A 30h write in mode 4 is ignored.
- R11: In mode 5 the program sequence is allowed (mode_o 7), and a busy_i fall returns to mode 5. The erase setup byte 80h is rejected, and the block stays in mode 5.
- R12: In mode 5 the autoselect sequence enters mode 6, and F0h returns to mode 5.
- R13: F0h written in the middle of an unlock or erase setup sequence, before the final command byte, abandons the sequence; a following partial sequence then starts no operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | One-cycle host write strobe |
| wr_addr | input | ADDR_W (19) | Write address |
| wr_data | input | 8 | Write data / command byte |
| busy_i | input | 1 | Embedded algorithm running; its fall ends program or erase |
| mode_o | output | 3 | Mode code: 0 read, 1 autoselect, 2 program, 3 window, 4 erase, 5 suspended, 6 suspended autoselect, 7 suspended program |
| prog_start_o | output | 1 | One-cycle program start pulse |
| prog_addr_o | output | ADDR_W (19) | Latched program address |
| prog_data_o | output | 8 | Latched program data |
| erase_start_o | output | 1 | One-cycle erase start pulse |
| erase_chip_o | output | 1 | Running erase covers the whole chip |
| sector_mask_o | output | 8 | Sectors selected for erase |
| win_done_o | output | 1 | Sector collection window has closed |

## Verification
A corrupted sequence step shows up at the write after the damage: a command byte that should have opened a mode leaves mode_o at its base value, or the reverse. The sweeps therefore check mode_o one cycle after each final write. A wrong window count moves the erase_start_o pulse away from the exact edge WIN_CYCLES after the last sector write, which the bench samples one cycle before and at that edge. A wrong suspend or begun record shows up as a missing or extra erase_start_o pulse at resume, or as a mode that does not return on the busy fall.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;
  localparam int CMD_AW = 11;

  localparam logic [CMD_AW-1:0] ADR_KEY1 = 11'h555;
  localparam logic [CMD_AW-1:0] ADR_KEY2 = 11'h2AA;

  localparam logic [7:0] KEY1_BYTE   = 8'hAA;
  localparam logic [7:0] KEY2_BYTE   = 8'h55;
  localparam logic [7:0] OP_PROG     = 8'hA0;
  localparam logic [7:0] OP_IDENT    = 8'h90;
  localparam logic [7:0] OP_ERSETUP  = 8'h80;
  localparam logic [7:0] OP_CHIP     = 8'h10;
  localparam logic [7:0] OP_SECTOR   = 8'h30;
  localparam logic [7:0] OP_SUSPEND  = 8'hB0;
  localparam logic [7:0] OP_ABANDON  = 8'hF0;

  typedef enum logic [2:0] {
    M_READ  = 3'd0,
    M_AUTO  = 3'd1,
    M_PROG  = 3'd2,
    M_WIN   = 3'd3,
    M_ERASE = 3'd4,
    M_SUSP  = 3'd5,
    M_SAUTO = 3'd6,
    M_SPROG = 3'd7
  } mode_e;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_K1   = 3'd1,
    S_K2   = 3'd2,
    S_PSET = 3'd3,
    S_ESET = 3'd4,
    S_EK1  = 3'd5,
    S_EK2  = 3'd6
  } seq_e;
endpackage

// File: rtl/nor_erase_window.sv
module nor_erase_window #(
  parameter int WIN_CYCLES = 12500
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic run,
  output logic expired
);
  localparam int CW = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
  localparam logic [CW-1:0] LOAD_VAL = CW'(WIN_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= LOAD_VAL;
    end else if (run && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = run && (cnt_q == '0);

  // R6: a freshly loaded window never reports expiry on the next cycle unless one cycle long
  AST_LOAD_NOT_EXPIRED: assert property (@(posedge clk) disable iff (rst)
    (load && WIN_CYCLES > 1) |=> (cnt_q != '0)); // R6
endmodule

// File: rtl/nor_sector_mask.sv
module nor_sector_mask #(
  parameter int SECT_BITS = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 set_all,
  input  logic                 set_en,
  input  logic [SECT_BITS-1:0] set_idx,
  output logic [(1<<SECT_BITS)-1:0] mask
);
  localparam int NS = 1 << SECT_BITS;

  logic [NS-1:0] mask_q;
  logic [NS-1:0] mask_nxt;

  for (genvar i = 0; i < NS; i++) begin : g_bit
    assign mask_nxt[i] = mask_q[i] | set_all |
                         (set_en && (set_idx == SECT_BITS'(i)));
  end

  always_ff @(posedge clk) begin
    if (rst || clr) mask_q <= '0;
    else            mask_q <= mask_nxt;
  end

  assign mask = mask_q;

  // selected sectors only accumulate until an explicit clear
  AST_MASK_MONOTONE: assert property (@(posedge clk) disable iff (rst)
    (!clr) |=> ((mask_q & $past(mask_q)) == $past(mask_q))); // R5
endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W     = 19,
  parameter int SECT_BITS  = 3,
  parameter int WIN_CYCLES = 12500
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_stb,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [7:0]                wr_data,
  input  logic                      busy_i,
  output logic [2:0]                mode_o,
  output logic                      prog_start_o,
  output logic [ADDR_W-1:0]         prog_addr_o,
  output logic [7:0]                prog_data_o,
  output logic                      erase_start_o,
  output logic                      erase_chip_o,
  output logic [(1<<SECT_BITS)-1:0] sector_mask_o,
  output logic                      win_done_o
);
  localparam int NS = 1 << SECT_BITS;

  mode_e mode_q, mode_d;
  seq_e  seq_q, seq_d;

  logic              pstart_q, pstart_d;
  logic              estart_q, estart_d;
  logic              chip_q, chip_d;
  logic              done_q, done_d;
  logic              begun_q, begun_d;
  logic              busy_q;
  logic [ADDR_W-1:0] paddr_q;
  logic [7:0]        pdata_q;

  logic lat_en, m_clr, m_all, m_set, win_load, win_exp;
  logic busy_fall, on_key1, on_key2;
  logic [SECT_BITS-1:0] sect_idx;
  logic [NS-1:0]        mask_w;

  assign busy_fall = busy_q && !busy_i;
  assign on_key1   = (wr_addr[CMD_AW-1:0] == ADR_KEY1);
  assign on_key2   = (wr_addr[CMD_AW-1:0] == ADR_KEY2);
  assign sect_idx  = wr_addr[ADDR_W-1 -: SECT_BITS];

  nor_erase_window #(.WIN_CYCLES(WIN_CYCLES)) u_win (
    .clk     (clk),
    .rst     (rst),
    .load    (win_load),
    .run     (mode_q == M_WIN),
    .expired (win_exp)
  );

  nor_sector_mask #(.SECT_BITS(SECT_BITS)) u_mask (
    .clk     (clk),
    .rst     (rst),
    .clr     (m_clr),
    .set_all (m_all),
    .set_en  (m_set),
    .set_idx (sect_idx),
    .mask    (mask_w)
  );

  always_comb begin
    mode_d   = mode_q;
    seq_d    = seq_q;
    pstart_d = 1'b0;
    estart_d = 1'b0;
    chip_d   = chip_q;
    done_d   = done_q;
    begun_d  = begun_q;
    lat_en   = 1'b0;
    m_clr    = 1'b0;
    m_all    = 1'b0;
    m_set    = 1'b0;
    win_load = 1'b0;

    case (mode_q)
      M_READ, M_SUSP: begin
        if (wr_stb) begin
          seq_d = S_IDLE;
          case (seq_q)
            S_IDLE: begin
              if (wr_data == KEY1_BYTE && on_key1) begin
                seq_d = S_K1;
              end else if (mode_q == M_SUSP && wr_data == OP_SECTOR) begin
                mode_d = M_ERASE;
                if (!begun_q) begin
                  estart_d = 1'b1;
                  begun_d  = 1'b1;
                end
              end
            end
            S_K1: if (wr_data == KEY2_BYTE && on_key2) seq_d = S_K2;
            S_K2: begin
              if (on_key1) begin
                case (wr_data)
                  OP_PROG:    seq_d  = S_PSET;
                  OP_IDENT:   mode_d = (mode_q == M_READ) ? M_AUTO : M_SAUTO;
                  OP_ERSETUP: if (mode_q == M_READ) seq_d = S_ESET;
                  default:    seq_d  = S_IDLE;
                endcase
              end
            end
            S_PSET: begin
              lat_en   = 1'b1;
              pstart_d = 1'b1;
              mode_d   = (mode_q == M_READ) ? M_PROG : M_SPROG;
            end
            S_ESET: if (wr_data == KEY1_BYTE && on_key1) seq_d = S_EK1;
            S_EK1:  if (wr_data == KEY2_BYTE && on_key2) seq_d = S_EK2;
            S_EK2: begin
              if (wr_data == OP_CHIP && on_key1) begin
                mode_d   = M_ERASE;
                chip_d   = 1'b1;
                m_all    = 1'b1;
                estart_d = 1'b1;
                begun_d  = 1'b1;
              end else if (wr_data == OP_SECTOR) begin
                mode_d   = M_WIN;
                m_set    = 1'b1;
                win_load = 1'b1;
                begun_d  = 1'b0;
                done_d   = 1'b0;
              end
            end
            default: seq_d = S_IDLE;
          endcase
        end
      end

      M_AUTO:  if (wr_stb && wr_data == OP_ABANDON) mode_d = M_READ;
      M_SAUTO: if (wr_stb && wr_data == OP_ABANDON) mode_d = M_SUSP;

      M_WIN: begin
        if (wr_stb) begin
          if (wr_data == OP_SECTOR) begin
            m_set    = 1'b1;
            win_load = 1'b1;
          end else if (wr_data == OP_SUSPEND) begin
            mode_d = M_SUSP;
            done_d = 1'b1;
          end else begin
            mode_d = M_READ;
            m_clr  = 1'b1;
          end
        end else if (win_exp) begin
          mode_d   = M_ERASE;
          estart_d = 1'b1;
          begun_d  = 1'b1;
          done_d   = 1'b1;
        end
      end

      M_PROG: if (busy_fall) mode_d = M_READ;

      M_ERASE: begin
        if (busy_fall) begin
          mode_d = M_READ;
          m_clr  = 1'b1;
          chip_d = 1'b0;
          done_d = 1'b0;
        end else if (wr_stb && wr_data == OP_SUSPEND && !chip_q) begin
          mode_d = M_SUSP;
        end
      end

      M_SPROG: if (busy_fall) mode_d = M_SUSP;

      default: mode_d = M_READ;
    endcase

    if (mode_d != mode_q) seq_d = S_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= M_READ;
      seq_q    <= S_IDLE;
      pstart_q <= 1'b0;
      estart_q <= 1'b0;
      chip_q   <= 1'b0;
      done_q   <= 1'b0;
      begun_q  <= 1'b0;
      busy_q   <= 1'b0;
      paddr_q  <= '0;
      pdata_q  <= '0;
    end else begin
      mode_q   <= mode_d;
      seq_q    <= seq_d;
      pstart_q <= pstart_d;
      estart_q <= estart_d;
      chip_q   <= chip_d;
      done_q   <= done_d;
      begun_q  <= begun_d;
      busy_q   <= busy_i;
      if (lat_en) begin
        paddr_q <= wr_addr;
        pdata_q <= wr_data;
      end
    end
  end

  assign mode_o        = mode_q;
  assign prog_start_o  = pstart_q;
  assign prog_addr_o   = paddr_q;
  assign prog_data_o   = pdata_q;
  assign erase_start_o = estart_q;
  assign erase_chip_o  = chip_q;
  assign sector_mask_o = mask_w;
  assign win_done_o    = done_q;

  AST_PROG_PULSE_MODE: assert property (@(posedge clk) disable iff (rst)
    prog_start_o |-> (mode_o == M_PROG || mode_o == M_SPROG)); // R3
  AST_AUTO_STICKY: assert property (@(posedge clk) disable iff (rst)
    (mode_o == M_AUTO && !(wr_stb && wr_data == OP_ABANDON)) |=> (mode_o == M_AUTO)); // R4
  AST_WIN_HAS_SECTOR: assert property (@(posedge clk) disable iff (rst)
    (mode_o == M_WIN) |-> (sector_mask_o != '0)); // R5
  AST_WIN_CLOSE: assert property (@(posedge clk) disable iff (rst)
    (mode_o == M_WIN && !wr_stb && win_exp) |=> (erase_start_o && mode_o == M_ERASE)); // R6
  AST_ERASE_PULSE_MODE: assert property (@(posedge clk) disable iff (rst)
    erase_start_o |-> (mode_o == M_ERASE)); // R7
  AST_PROG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mode_o == M_PROG && !busy_fall) |=> (mode_o == M_PROG)); // R8
  AST_CHIP_NO_SUSPEND: assert property (@(posedge clk) disable iff (rst)
    (mode_o == M_ERASE && erase_chip_o && !busy_fall) |=> (mode_o == M_ERASE)); // R9
endmodule

// File: tb/nor_cmd_decoder_test.sv
module nor_cmd_decoder_test;
  localparam int AW = 19;
  localparam int W  = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_stb = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic          busy_i = 1'b0;
  logic [2:0]    mode_o;
  logic          prog_start_o, erase_start_o, erase_chip_o, win_done_o;
  logic [AW-1:0] prog_addr_o;
  logic [7:0]    prog_data_o;
  logic [7:0]    sector_mask_o;

  int nvec = 0;
  int nerr = 0;

  always #2 clk = ~clk;

  nor_cmd_decoder #(.ADDR_W(AW), .SECT_BITS(3), .WIN_CYCLES(W)) uut (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy_i(busy_i), .mode_o(mode_o), .prog_start_o(prog_start_o),
    .prog_addr_o(prog_addr_o), .prog_data_o(prog_data_o),
    .erase_start_o(erase_start_o), .erase_chip_o(erase_chip_o),
    .sector_mask_o(sector_mask_o), .win_done_o(win_done_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_stb = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic unlock();
    wr(19'h00555, 8'hAA);
    wr(19'h002AA, 8'h55);
  endtask

  task automatic finish_op();
    busy_i = 1'b1; idle(2);
    busy_i = 1'b0; idle(1);
  endtask

  task automatic sector_seq(input logic [2:0] s);
    unlock(); wr(19'h00555, 8'h80);
    unlock(); wr({s, 16'h0123}, 8'h30);
  endtask

  initial begin
    #(4 * 150000);
    nerr++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    // R1 reset state
    chk("R1 mode", 32'(mode_o), 0);
    chk("R1 mask", 32'(sector_mask_o), 0);
    chk("R1 flags", {28'd0, prog_start_o, erase_start_o, erase_chip_o, win_done_o}, 0);

    // R2 sweep of the first unlock byte
    for (int d = 0; d < 256; d++) begin
      wr(19'h00555, 8'(d)); wr(19'h002AA, 8'h55); wr(19'h00555, 8'h90);
      chk("R2 first byte sweep", 32'(mode_o), (d == 8'hAA) ? 1 : 0);
      if (d == 8'hAA) wr(19'h0, 8'hF0);
    end
    // R2 second cycle address: only low 11 bits compared
    for (int k = 0; k < 8; k++) begin
      logic [AW-1:0] a;
      a = {3'(k), 5'(k * 3), 11'h2AA};
      if (k[0]) a[3:0] = 4'h0;
      wr(19'h7F555, 8'hAA); wr(a, 8'h55); wr(19'h40555, 8'h90);
      chk("R2 address sweep", 32'(mode_o), k[0] ? 0 : 1);
      wr(19'h12345, 8'hF0);
    end

    // R4 autoselect ignores other commands
    unlock(); wr(19'h00555, 8'h90);
    unlock(); wr(19'h00555, 8'hA0); wr(19'h00100, 8'h12);
    chk("R4 autoselect sticky", 32'(mode_o), 1);
    chk("R4 no program pulse", 32'(prog_start_o), 0);
    wr(19'h00000, 8'hF0);
    chk("R4 exit", 32'(mode_o), 0);

    // R3 program sweep, R8 commands ignored while running
    for (int i = 0; i < 12; i++) begin
      logic [AW-1:0] pa;
      logic [7:0]    pd;
      pa = 19'((i * 32'h7777 + 5) & 32'h7FFFF);
      pd = (i == 5) ? 8'hF0 : 8'((i * 17) ^ 8'h5A);
      unlock(); wr(19'h00555, 8'hA0); wr(pa, pd);
      chk("R3 pulse", 32'(prog_start_o), 1);
      chk("R3 mode", 32'(mode_o), 2);
      chk("R3 addr", 32'(prog_addr_o), 32'(pa));
      chk("R3 data", 32'(prog_data_o), 32'(pd));
      idle(1);
      chk("R3 single pulse", 32'(prog_start_o), 0);
      busy_i = 1'b1;
      wr(19'h0, 8'hF0); wr(19'h0, 8'hB0);
      chk("R8 ignores F0/B0 in program (R9)", 32'(mode_o), 2);
      busy_i = 1'b0; idle(1);
      chk("R8 program done", 32'(mode_o), 0);
    end

    // R13 F0 in mid sequence
    wr(19'h00555, 8'hAA); wr(19'h0, 8'hF0); wr(19'h002AA, 8'h55); wr(19'h00555, 8'h90);
    chk("R13 after first key", 32'(mode_o), 0);
    unlock(); wr(19'h00555, 8'h80); wr(19'h0, 8'hF0); unlock(); wr(19'h00555, 8'h10);
    chk("R13 after erase setup mode", 32'(mode_o), 0);
    chk("R13 after erase setup start", 32'(erase_start_o), 0);

    // R7 chip erase; R9 suspend ignored
    unlock(); wr(19'h00555, 8'h80); unlock(); wr(19'h00555, 8'h10);
    chk("R7 start", 32'(erase_start_o), 1);
    chk("R7 mode", 32'(mode_o), 4);
    chk("R7 chip", 32'(erase_chip_o), 1);
    chk("R7 mask", 32'(sector_mask_o), 32'hFF);
    busy_i = 1'b1;
    wr(19'h0, 8'hB0);
    chk("R9 chip erase not suspended", 32'(mode_o), 4);
    busy_i = 1'b0; idle(1);
    chk("R8 chip done", {24'd0, erase_chip_o, 4'(mode_o), 3'd0}, 0);
    chk("R8 mask cleared", 32'(sector_mask_o), 0);

    // R5/R6 every sector alone, exact window edge
    for (int s = 0; s < 8; s++) begin
      sector_seq(3'(s));
      chk("R5 mode", 32'(mode_o), 3);
      chk("R5 mask", 32'(sector_mask_o), 32'(1 << s));
      idle(W - 1);
      chk("R6 before edge", {30'd0, erase_start_o, win_done_o}, 0);
      idle(1);
      chk("R6 at edge", {28'd0, 1'b0, 4'(mode_o) == 4'd4, erase_start_o, win_done_o}, 32'h7);
      idle(1);
      chk("R6 single pulse", 32'(erase_start_o), 0);
      finish_op();
      chk("R8 sector done", {28'd0, mode_o, win_done_o}, 0);
    end

    // R5 retrigger with a second sector
    sector_seq(3'd2);
    idle(W - 3);
    wr({3'd5, 16'hBEEF}, 8'h30);
    idle(W - 1);
    chk("R5 retrigger still open", 32'(mode_o), 3);
    chk("R5 two sectors", 32'(sector_mask_o), 32'h24);
    idle(1);
    chk("R5 retrigger close", {31'd0, erase_start_o}, 1);
    finish_op();

    // R6 abort with another command
    sector_seq(3'd6);
    wr(19'h00555, 8'h90);
    chk("R6 abort mode", 32'(mode_o), 0);
    chk("R6 abort mask", 32'(sector_mask_o), 0);

    // R9 suspend running sector erase, R11/R12 inside suspend, R10 resume
    sector_seq(3'd1);
    idle(W);
    busy_i = 1'b1;
    wr(19'h0, 8'hB0);
    chk("R9 suspended", 32'(mode_o), 5);
    chk("R9 done flag", 32'(win_done_o), 1);
    busy_i = 1'b0; idle(1);
    chk("R9 busy fall ignored in suspend", 32'(mode_o), 5);
    unlock(); wr(19'h00555, 8'hA0); wr(19'h3AB12, 8'h66);
    chk("R11 suspended program", 32'(mode_o), 7);
    chk("R11 pulse", 32'(prog_start_o), 1);
    chk("R11 data", 32'(prog_data_o), 32'h66);
    finish_op();
    chk("R11 back to suspend", 32'(mode_o), 5);
    unlock(); wr(19'h00555, 8'h80); unlock(); wr(19'h20000, 8'h30);
    chk("R11 erase setup rejected", 32'(mode_o), 5);
    unlock(); wr(19'h00555, 8'h90);
    chk("R12 suspended autoselect", 32'(mode_o), 6);
    wr(19'h00555, 8'h30);
    chk("R12 ignores other", 32'(mode_o), 6);
    wr(19'h0, 8'hF0);
    chk("R12 exit", 32'(mode_o), 5);
    wr(19'h0, 8'h30);
    chk("R10 resume", 32'(mode_o), 4);
    chk("R10 no restart", 32'(erase_start_o), 0);
    chk("R10 mask kept", 32'(sector_mask_o), 32'h02);
    wr(19'h0, 8'h30);
    chk("R10 repeated resume ignored", {31'd0, mode_o == 3'd4 && !erase_start_o}, 1);
    wr(19'h0, 8'hB0);
    chk("R9 suspend again", 32'(mode_o), 5);
    wr(19'h0, 8'h30);
    finish_op();
    chk("R8 erase end after resume", 32'(mode_o), 0);

    // R9 suspend during window, R10 resume starts erase
    sector_seq(3'd7);
    idle(3);
    wr(19'h0, 8'hB0);
    chk("R9 window suspend mode", 32'(mode_o), 5);
    chk("R9 window suspend flags", {30'd0, erase_start_o, win_done_o}, 1);
    idle(W + 2);
    chk("R9 window stopped", {29'd0, mode_o == 3'd5, erase_start_o, 1'b0}, 4);
    wr(19'h0, 8'h30);
    chk("R10 resume starts erase", {30'd0, mode_o == 3'd4, erase_start_o}, 3);
    finish_op();
    chk("R8 final", 32'(mode_o), 0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule